// File: doc/BRIEF.md
# Spindle Speed Window Regulator

This block keeps a disk spindle turning at its nominal rate. It counts reference ticks (cycles in which `tick_en` is high) between successive once-per-revolution index pulses. When an index pulse arrives, it compares the count with four thresholds: fast limit 1980, nominal 2000, slow limit 2020 and loss 2048. From that comparison it decides whether motor current is allowed for the next revolution, and whether writes must be blocked because the speed lies outside the allowed window.

Two hold timers gate the motor path. A start-up timer is armed by reset and keeps the motor enabled for a fixed number of ticks, whatever the speed feedback says. A retriggerable rotation detector is reloaded by every commutator cell pulse. While the disk keeps turning it never expires, so after start-up it lets the regulation decision drive the motor. Timer lengths are parameters counted in ticks, not in real time.

Top module: `spindle_speed_regulator`

## Requirements
- R1: The revolution count rises by one in each cycle with `tick_en` high, returns to 0 in a cycle with `index_p` high (index takes priority over a tick in the same cycle), and stops at 2048 rather than wrapping.
- R2: An index pulse that lands with a count below 1980 (too fast) sets `speed_det` high from the next cycle.
- R3: An index pulse that lands with a count above 2020 sets `speed_det` high from the next cycle. This includes a saturated count of 2048.
- R4: An index pulse that lands with a count from 1980 to 2020 inclusive drives `speed_det` low from the next cycle. `speed_det` changes only on index pulses.
- R5: `speed_loss` is high while the count sits at 2048 and goes low in the cycle after an index pulse.
- R6: An index pulse with a count below 2000 clears the regulation flag, and one with a count of 2000 or more sets it. Once start-up has ended, `motor_on` follows this flag from the next cycle while rotation is present.
- R7: After reset, `motor_on` stays high for START_TICKS ticks whatever the index timing is.
- R8: Each `cell_p` pulse restarts a ROT_TICKS window of rotation presence. When start-up has ended and no cell pulse has arrived for ROT_TICKS ticks, `motor_on` is low.
- R9: During and right after reset, `motor_on` is high, `speed_det` is high (writes blocked) and `speed_loss` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference tick qualifier |
| index_p | input | 1 | Fixed index pulse, one cycle per revolution |
| cell_p | input | 1 | Commutator cell pulse, once per revolution |
| motor_on | output | 1 | Motor current enable |
| speed_det | output | 1 | Write inhibit, high when speed is outside the window |
| speed_loss | output | 1 | Severe speed loss, count reached 2048 |

## Verification
The assertions check on every cycle that the count clears on an index pulse and holds once saturated. They also check how each index landing maps onto `speed_det` across the three window regions, that `speed_det` stays steady between index pulses, that `speed_loss` drops after an index, and that an early index shuts the motor off unless start-up is still active. Some behaviours need a sequence of revolutions and only the bench scenarios can show them: the start-up hold overriding a slow-down decision, the rotation window running out when cell pulses stop, an index winning over a tick in the same cycle, and the inclusive window boundaries.

// File: rtl/spd_pkg.sv
// Package spd_pkg
// Holds the types shared by the spindle speed regulator modules.
// Assumes every count comparison is made against the live revolution count.
package spd_pkg;

    // Threshold decode of the live revolution count.
    typedef struct packed {
        logic below_fast;   // count < fast limit
        logic below_nom;    // count < nominal
        logic above_slow;   // count > slow limit
        logic at_loss;      // count saturated at loss value
    } spd_decode_t;

endpackage

// File: rtl/spd_rev_counter.sv
// Module spd_rev_counter
// Counts qualified ticks since the last index pulse, saturating at LOSS_CNT,
// and decodes the count against the regulator thresholds.
// Assumes FAST_CNT < NOM_CNT < SLOW_CNT < LOSS_CNT.
module spd_rev_counter
    import spd_pkg::*;
#(
    parameter int FAST_CNT = 1980,
    parameter int NOM_CNT  = 2000,
    parameter int SLOW_CNT = 2020,
    parameter int LOSS_CNT = 2048,
    parameter int CNT_W    = $clog2(LOSS_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             index_p,
    output logic [CNT_W-1:0] cnt,
    output spd_decode_t      dec
);

    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_CNT);
    localparam logic [CNT_W-1:0] NOM_L  = CNT_W'(NOM_CNT);
    localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(SLOW_CNT);
    localparam logic [CNT_W-1:0] LOSS_L = CNT_W'(LOSS_CNT);

    // Tick counter: cleared by index, saturating at the loss value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (index_p) begin
            cnt <= '0;
        end else if (tick_en && (cnt != LOSS_L)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Threshold decode of the current count.
    always_comb begin
        dec.below_fast = (cnt <  FAST_L);
        dec.below_nom  = (cnt <  NOM_L);
        dec.above_slow = (cnt >  SLOW_L);
        dec.at_loss    = (cnt == LOSS_L);
    end

endmodule

// File: rtl/spd_decision.sv
// Module spd_decision
// Samples the threshold decode at each index pulse and holds the write
// inhibit flag and the regulation (drive request) flag until the next index.
// Assumes index_p is a single-cycle pulse.
module spd_decision
    import spd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        index_p,
    input  spd_decode_t dec,
    output logic        speed_det,
    output logic        drive_req
);

    // Capture window verdict and regulation decision on index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_det <= 1'b1;
            drive_req <= 1'b1;
        end else if (index_p) begin
            speed_det <= dec.below_fast | dec.above_slow;
            drive_req <= ~dec.below_nom;
        end
    end

endmodule

// File: rtl/spd_oneshot.sv
// Module spd_oneshot
// Retriggerable tick-counted one-shot. Active while its remaining count is
// non-zero; trig reloads DURATION; ARMED selects whether reset starts it.
// Assumes DURATION >= 1.
module spd_oneshot #(
    parameter int DURATION = 4096,
    parameter bit ARMED    = 1'b0,
    parameter int REM_W    = $clog2(DURATION + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic trig,
    output logic active
);

    localparam logic [REM_W-1:0] DUR_L   = REM_W'(DURATION);
    localparam logic [REM_W-1:0] RESET_L = ARMED ? DUR_L : '0;

    logic [REM_W-1:0] remain;

    // Reload on trigger, count down on ticks until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= RESET_L;
        end else if (trig) begin
            remain <= DUR_L;
        end else if (tick_en && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    // Output is high while time remains.
    assign active = (remain != '0);

endmodule

// File: rtl/spindle_speed_regulator.sv
// Module spindle_speed_regulator
// Top level: measures revolution time in ticks, judges it against a speed
// window, pulses the motor enable to hold nominal speed, and gates the motor
// path with a start-up hold and a rotation-present detector.
// Assumes one index and one cell pulse per revolution, each one cycle long.
module spindle_speed_regulator
    import spd_pkg::*;
#(
    parameter int FAST_CNT    = 1980,
    parameter int NOM_CNT     = 2000,
    parameter int SLOW_CNT    = 2020,
    parameter int LOSS_CNT    = 2048,
    parameter int START_TICKS = 6000,
    parameter int ROT_TICKS   = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic index_p,
    input  logic cell_p,
    output logic motor_on,
    output logic speed_det,
    output logic speed_loss
);

    localparam int CNT_W = $clog2(LOSS_CNT + 1);

    logic [CNT_W-1:0] rev_cnt;
    spd_decode_t      dec;
    logic             drive_req;
    logic             start_act;
    logic             rot_act;

    spd_rev_counter #(
        .FAST_CNT (FAST_CNT),
        .NOM_CNT  (NOM_CNT),
        .SLOW_CNT (SLOW_CNT),
        .LOSS_CNT (LOSS_CNT),
        .CNT_W    (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .index_p (index_p),
        .cnt     (rev_cnt),
        .dec     (dec)
    );

    spd_decision u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .index_p   (index_p),
        .dec       (dec),
        .speed_det (speed_det),
        .drive_req (drive_req)
    );

    spd_oneshot #(
        .DURATION (START_TICKS),
        .ARMED    (1'b1)
    ) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .trig    (1'b0),
        .active  (start_act)
    );

    spd_oneshot #(
        .DURATION (ROT_TICKS),
        .ARMED    (1'b0)
    ) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .trig    (cell_p),
        .active  (rot_act)
    );

    // Motor enable: start-up hold, or rotation present with drive requested.
    assign motor_on   = start_act | (rot_act & drive_req);

    // Severe loss flag straight from the saturated count decode.
    assign speed_loss = dec.at_loss;

endmodule

// File: rtl/spd_reg_chk.sv
// Module spd_reg_chk
// Assertion checker bound to spindle_speed_regulator.
module spd_reg_chk #(
    parameter int FAST_CNT = 1980,
    parameter int NOM_CNT  = 2000,
    parameter int SLOW_CNT = 2020,
    parameter int LOSS_CNT = 2048,
    parameter int CNT_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             index_p,
    input logic [CNT_W-1:0] rev_cnt,
    input logic             start_act,
    input logic             motor_on,
    input logic             speed_det,
    input logic             speed_loss
);

    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_CNT);
    localparam logic [CNT_W-1:0] NOM_L  = CNT_W'(NOM_CNT);
    localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(SLOW_CNT);
    localparam logic [CNT_W-1:0] LOSS_L = CNT_W'(LOSS_CNT);

    a_r1_clear_on_index: assert property (@(posedge clk) disable iff (!rst_n)
        index_p |=> (rev_cnt == '0));

    a_r1_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_cnt == LOSS_L) && !index_p |=> (rev_cnt == LOSS_L));

    a_r2_fast_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        index_p && (rev_cnt < FAST_L) |=> speed_det);

    a_r3_slow_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        index_p && (rev_cnt > SLOW_L) |=> speed_det);

    a_r4_window_allow: assert property (@(posedge clk) disable iff (!rst_n)
        index_p && (rev_cnt >= FAST_L) && (rev_cnt <= SLOW_L) |=> !speed_det);

    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !index_p |=> $stable(speed_det));

    a_r5_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        index_p |=> !speed_loss);

    a_r6_slow_down: assert property (@(posedge clk) disable iff (!rst_n)
        index_p && (rev_cnt < NOM_L) |=> (!motor_on || start_act));

endmodule

bind spindle_speed_regulator spd_reg_chk #(
    .FAST_CNT (FAST_CNT),
    .NOM_CNT  (NOM_CNT),
    .SLOW_CNT (SLOW_CNT),
    .LOSS_CNT (LOSS_CNT),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .index_p    (index_p),
    .rev_cnt    (rev_cnt),
    .start_act  (start_act),
    .motor_on   (motor_on),
    .speed_det  (speed_det),
    .speed_loss (speed_loss)
);

// File: tb/sim_spindle_speed_regulator.sv
// Scoreboard bench for spindle_speed_regulator.
module sim_spindle_speed_regulator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic index_p = 1'b0;
    logic cell_p = 1'b0;
    logic motor_on, speed_det, speed_loss;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        bit    ck_mot, ck_det, ck_loss;
        bit    mot, det, loss;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    spindle_speed_regulator u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .index_p    (index_p),
        .cell_p     (cell_p),
        .motor_on   (motor_on),
        .speed_det  (speed_det),
        .speed_loss (speed_loss)
    );

    // Monitor: pop expectations and compare away from the clock edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.ck_mot) begin
                tests++;
                if (motor_on !== e.mot) begin
                    fails++;
                    $display("FAIL %s motor_on actual=%b expected=%b", e.req, motor_on, e.mot);
                end
            end
            if (e.ck_det) begin
                tests++;
                if (speed_det !== e.det) begin
                    fails++;
                    $display("FAIL %s speed_det actual=%b expected=%b", e.req, speed_det, e.det);
                end
            end
            if (e.ck_loss) begin
                tests++;
                if (speed_loss !== e.loss) begin
                    fails++;
                    $display("FAIL %s speed_loss actual=%b expected=%b", e.req, speed_loss, e.loss);
                end
            end
        end
    end

    // Push one expectation; it is compared at the coming negative edge.
    task automatic expect_out(string req, bit cm, bit m, bit cd, bit d, bit cl, bit l);
        exp_t e;
        e.req = req; e.ck_mot = cm; e.mot = m; e.ck_det = cd; e.det = d;
        e.ck_loss = cl; e.loss = l;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    // Drive one cycle of inputs, then settle past the capturing edge.
    task automatic step(bit te, bit idx, bit cel);
        tick_en = te; index_p = idx; cell_p = cel;
        @(posedge clk);
        #2;
        tick_en = 1'b0; index_p = 1'b0; cell_p = 1'b0;
    endtask

    // One revolution: n ticks (first with a cell pulse) then an index.
    task automatic rev(int n);
        step(1'b1, 1'b0, 1'b1);
        for (int i = 1; i < n; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state
        expect_out("R9", 1, 1, 1, 1, 1, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        expect_out("R9", 1, 1, 1, 1, 1, 0);

        // R2 fast; R7 start hold keeps motor on (ticks used 1900)
        rev(1900);
        expect_out("R2/R7", 1, 1, 1, 1, 0, 0);
        // R4 nominal in window
        rev(2000);
        expect_out("R4", 1, 1, 1, 0, 0, 0);
        // R4 lower bound; R7 start still overrides slow-down (5880 ticks)
        rev(1980);
        expect_out("R4/R7", 1, 1, 1, 0, 0, 0);
        // R4 upper bound; start over, R8 rotation keeps motor enabled
        rev(2020);
        expect_out("R4/R8", 1, 1, 1, 0, 0, 0);
        // R2 boundary just too fast; R6 slow-down
        rev(1979);
        expect_out("R2/R6", 1, 0, 1, 1, 0, 0);
        // R3 just too slow; R6 drive
        rev(2021);
        expect_out("R3/R6", 1, 1, 1, 1, 0, 0);
        // R6 boundary below nominal
        rev(1999);
        expect_out("R6", 1, 0, 1, 0, 0, 0);
        // R6 at nominal
        rev(2000);
        expect_out("R6", 1, 1, 1, 0, 0, 0);

        // R5/R1 loss: saturate and stay
        step(1'b1, 1'b0, 1'b1);
        for (int i = 1; i < 2048; i++) step(1'b1, 1'b0, 1'b0);
        expect_out("R5", 0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0);
        expect_out("R1", 0, 0, 1, 0, 1, 1);   // R4 no change without index
        step(1'b0, 1'b1, 1'b0);
        expect_out("R3/R5", 0, 0, 1, 1, 1, 0);

        // R1 index beats tick in the same cycle: next count stays at 2020
        step(1'b1, 1'b1, 1'b0);
        rev(2020);
        expect_out("R1", 0, 0, 1, 0, 0, 0);

        // R8 rotation window expires without cell pulses
        for (int i = 0; i < 4200; i++) step(1'b1, 1'b0, 1'b0);
        expect_out("R8", 1, 0, 0, 0, 0, 0);
        step(1'b1, 1'b0, 1'b1);
        expect_out("R8", 1, 1, 0, 0, 0, 0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule